// File: doc/BRIEF.md
# Nine-Bit Multiprocessor UART Core

This block is a full-duplex asynchronous serial port controlled through one byte-wide control/status register and one data register. It sends and receives frames with eight data bits, or with a ninth data bit. In the nine-bit case the receiver can discard every frame whose ninth bit is 0. This lets many nodes share one line and wake only on address frames. A single qualification bit in the control register has two meanings. In eight-bit mode it rejects frames whose stop bit is not 1. In nine-bit mode it rejects frames whose ninth bit is not 1.

The host reaches the block through a valid/ready register channel. Control writes and all reads are always accepted. A write to the data register starts a transmit frame. While a frame is still being sent, that write is back-pressured: `reg_ready` is held low and the host must keep `reg_valid`, `reg_write`, `reg_addr` and `reg_wdata` stable until `reg_ready` is seen high at a clock edge. Reads return data in the same cycle and have no side effects. An external tick paces both directions at sixteen ticks per bit. The interrupt output is high while either completion flag is set.

Register map. Address 0 is the control register. Address 1 reads the last accepted received byte and, when written, supplies the next byte to transmit. Control bits:
- bit 0: mode, 0 selects eight-bit frames and 1 selects nine-bit frames.
- bit 1: receive enable.
- bit 2: qualification.
- bit 3: ninth bit to transmit.
- bit 4: captured ninth bit (read-only).
- bit 5: transmit flag.
- bit 6: reads 1.
- bit 7: receive flag.

Top module: `uart9_core`

## Requirements
- R1: After reset the control register reads 0x40, `tx_o` is high and `irq_o` is low.
- R2: Control bit 6 always reads 1, and writes to it and to bit 4 have no effect.
- R3: A transmit frame is a 0 start bit, then eight data bits LSB first, then (nine-bit mode only) the control bit 3 value, then a 1 stop bit. Each bit lasts 16 ticks, and the line idles high.
- R4: The transmit flag (bit 5) rises as the stop bit begins. In eight-bit mode that is right after the eighth data bit, and in nine-bit mode right after the ninth bit.
- R5: While a frame is being sent, a data-register write sees `reg_ready` low and is not accepted. When idle, the write is accepted and starts a frame.
- R6: A low level that is gone by the middle of the start bit is dropped, and the receiver returns to idle with no frame.
- R7: With receive enable (bit 1) at 0, no frame is received: the receive flag and the data register do not change.
- R8: In eight-bit mode with qualification on, the receive flag is raised only for a stop bit of 1. With qualification off, the stop level is ignored. The captured ninth bit holds the stop bit.
- R9: In nine-bit mode with qualification on, the receive flag is raised only for a ninth bit of 1. With qualification off, any ninth bit is accepted. The captured ninth bit holds the ninth data bit.
- R10: A frame rejected by qualification leaves the data register and the captured ninth bit unchanged.
- R11: The receive flag rises at the stop-bit sample. Each flag stays set until a control write puts 0 in its bit, and writing 1 does not set it. A hardware set wins over a clear in the same cycle.
- R12: `irq_o` is high exactly while the transmit flag or the receive flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted this cycle |
| reg_write | input | 1 | 1 write, 0 read |
| reg_addr | input | 1 | 0 control, 1 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |
| irq_o | output | 1 | Interrupt request |

## Verification
The receive flag can be set by a stop-bit sample and cleared by a control write in the same clock cycle. The bench provokes this collision by counting clock edges from the falling start edge, so that a clearing control write lands exactly on the edge where the stop bit is sampled. The bench then judges the outcome by reading the control register: the flag must still be set and the data register must hold the new byte.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int BYTE_W     = 8;
  localparam int CTRL_MODE9 = 0;
  localparam int CTRL_RXEN  = 1;
  localparam int CTRL_QUAL  = 2;
  localparam int CTRL_TXB8  = 3;
  localparam int CTRL_RXB8  = 4;
  localparam int CTRL_TXF   = 5;
  localparam int CTRL_ONE   = 6;
  localparam int CTRL_RXF   = 7;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef enum logic [2:0] {
    FS_IDLE, FS_START, FS_DATA, FS_NINTH, FS_STOP
  } frame_state_e;

  typedef struct packed {
    logic mode9;
    logic rx_en;
    logic qual;
    logic tx_b8;
  } uart_cfg_t;
endpackage

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  input  logic          mode9,
  input  logic          b8,
  output logic          tx_o,
  output logic          busy,
  output logic          done
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] TOP  = IDX_W'(DW - 1);

  frame_state_e     state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    sh;
  logic             nine_q, b8_q;
  logic             bit_end;

  assign bit_end = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FS_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      nine_q <= 1'b0;
      b8_q   <= 1'b0;
    end else if (state == FS_IDLE) begin
      if (start) begin
        sh     <= data;
        nine_q <= mode9;
        b8_q   <= b8;
        cnt    <= '0;
        state  <= FS_START;
      end
    end else if (tick) begin
      if (cnt != LAST) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        unique case (state)
          FS_START: begin
            idx   <= '0;
            state <= FS_DATA;
          end
          FS_DATA: begin
            sh <= sh >> 1;
            if (idx == TOP) state <= nine_q ? FS_NINTH : FS_STOP;
            else            idx   <= idx + 1'b1;
          end
          FS_NINTH: state <= FS_STOP;
          default:  state <= FS_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      FS_START: tx_o = 1'b0;
      FS_DATA:  tx_o = sh[0];
      FS_NINTH: tx_o = b8_q;
      default:  tx_o = 1'b1;
    endcase
  end

  assign busy = (state != FS_IDLE);
  assign done = bit_end &&
                ((state == FS_DATA && idx == TOP && !nine_q) || state == FS_NINTH);
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int DW   = BYTE_W,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_i,
  input  logic          en,
  input  logic          mode9,
  input  logic          qual,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit8
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [IDX_W-1:0] TOP  = IDX_W'(DW - 1);

  logic             rx_s;
  frame_state_e     state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    sh;
  logic             nine_q, ninth_q;
  logic             frame_end;

  generate
    if (SYNC <= 1) begin : g_sync1
      logic s1;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) s1 <= 1'b1;
        else        s1 <= rx_i;
      assign rx_s = s1;
    end else begin : g_syncn
      logic [SYNC-1:0] chain;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC-2:0], rx_i};
      assign rx_s = chain[SYNC-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FS_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      nine_q  <= 1'b0;
      ninth_q <= 1'b0;
    end else if (!en) begin
      state <= FS_IDLE;
      cnt   <= '0;
    end else if (tick) begin
      unique case (state)
        FS_IDLE: begin
          if (!rx_s) begin
            state  <= FS_START;
            cnt    <= '0;
            nine_q <= mode9;
          end
        end
        FS_START: begin
          if (cnt == MID) begin
            cnt   <= '0;
            idx   <= '0;
            state <= rx_s ? FS_IDLE : FS_DATA;
          end else cnt <= cnt + 1'b1;
        end
        FS_DATA: begin
          if (cnt == LAST) begin
            cnt <= '0;
            sh  <= {rx_s, sh[DW-1:1]};
            if (idx == TOP) state <= nine_q ? FS_NINTH : FS_STOP;
            else            idx   <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        FS_NINTH: begin
          if (cnt == LAST) begin
            cnt     <= '0;
            ninth_q <= rx_s;
            state   <= FS_STOP;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= FS_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign frame_end = en && tick && (state == FS_STOP) && (cnt == LAST);
  assign bit8      = nine_q ? ninth_q : rx_s;
  assign done      = frame_end && (!qual || bit8);
  assign data      = sh;
endmodule

// File: rtl/uart9_regs.sv
module uart9_regs
  import uart9_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_bit8,
  output uart_cfg_t         cfg,
  output logic              flag_tx,
  output logic              flag_rx,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_b8,
  output logic [BYTE_W-1:0] ctrl_rd
);
  logic clr_tx, clr_rx;
  logic unused_wbits;

  assign clr_tx       = wr_ctrl && !wdata[CTRL_TXF];
  assign clr_rx       = wr_ctrl && !wdata[CTRL_RXF];
  assign unused_wbits = wdata[CTRL_ONE] ^ wdata[CTRL_RXB8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      flag_tx <= 1'b0;
      flag_rx <= 1'b0;
      rx_data <= '0;
      rx_b8   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cfg.mode9 <= wdata[CTRL_MODE9];
        cfg.rx_en <= wdata[CTRL_RXEN];
        cfg.qual  <= wdata[CTRL_QUAL];
        cfg.tx_b8 <= wdata[CTRL_TXB8];
      end
      if (tx_done)     flag_tx <= 1'b1;
      else if (clr_tx) flag_tx <= 1'b0;
      if (rx_done)     flag_rx <= 1'b1;
      else if (clr_rx) flag_rx <= 1'b0;
      if (rx_done) begin
        rx_data <= rx_byte;
        rx_b8   <= rx_bit8;
      end
    end
  end

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[CTRL_MODE9] = cfg.mode9;
    ctrl_rd[CTRL_RXEN]  = cfg.rx_en;
    ctrl_rd[CTRL_QUAL]  = cfg.qual;
    ctrl_rd[CTRL_TXB8]  = cfg.tx_b8;
    ctrl_rd[CTRL_RXB8]  = rx_b8;
    ctrl_rd[CTRL_TXF]   = flag_tx;
    ctrl_rd[CTRL_ONE]   = 1'b1;
    ctrl_rd[CTRL_RXF]   = flag_rx;
  end
endmodule

// File: rtl/uart9_core.sv
module uart9_core
  import uart9_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic              reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              tx_o,
  input  logic              rx_i,
  output logic              irq_o
);
  uart_cfg_t         cfg;
  logic              tx_busy, tx_done, tx_start, wr_ctrl, accept;
  logic              rx_done, rx_bit8;
  logic [BYTE_W-1:0] rx_byte, rx_data, ctrl_rd;
  logic              flag_tx, flag_rx, rx_b8_q;

  assign reg_ready = !(reg_write && reg_addr == ADDR_DATA && tx_busy);
  assign accept    = reg_valid && reg_ready;
  assign wr_ctrl   = accept && reg_write && reg_addr == ADDR_CTRL;
  assign tx_start  = accept && reg_write && reg_addr == ADDR_DATA;
  assign reg_rdata = (reg_addr == ADDR_CTRL) ? ctrl_rd : rx_data;
  assign irq_o     = flag_tx | flag_rx;

  uart9_tx #(.OVS(OVS), .DW(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(tx_start),
    .data(reg_wdata), .mode9(cfg.mode9), .b8(cfg.tx_b8),
    .tx_o(tx_o), .busy(tx_busy), .done(tx_done)
  );

  uart9_rx #(.OVS(OVS), .DW(BYTE_W), .SYNC(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx_i(rx_i),
    .en(cfg.rx_en), .mode9(cfg.mode9), .qual(cfg.qual),
    .done(rx_done), .data(rx_byte), .bit8(rx_bit8)
  );

  uart9_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
    .tx_done(tx_done), .rx_done(rx_done), .rx_byte(rx_byte), .rx_bit8(rx_bit8),
    .cfg(cfg), .flag_tx(flag_tx), .flag_rx(flag_rx), .rx_data(rx_data),
    .rx_b8(rx_b8_q), .ctrl_rd(ctrl_rd)
  );
endmodule

// File: rtl/uart9_core_chk.sv
module uart9_core_chk
  import uart9_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_ready,
  input logic              reg_write,
  input logic              reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic              tx_o,
  input logic              tx_busy,
  input logic              flag_tx,
  input logic              flag_rx,
  input uart_cfg_t         cfg,
  input logic              rx_b8_q,
  input logic              irq_o
);
  assert_ctrl_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && reg_addr == ADDR_CTRL) |-> reg_rdata[CTRL_ONE]);

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o);

  assert_txflag_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_tx) |-> (tx_o && tx_busy));

  assert_tx_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(reg_valid && reg_ready && reg_write && reg_addr == ADDR_DATA));

  assert_rx_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_rx) |-> $past(cfg.rx_en));

  // R8 and R9: a qualified accept always has a captured ninth bit of 1
  assert_qual_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_rx) && $past(cfg.qual)) |-> rx_b8_q);

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_rx) |-> $past(reg_valid && reg_write && reg_addr == ADDR_CTRL &&
                             !reg_wdata[CTRL_RXF]));

  assert_irq_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($rose(flag_tx) || $rose(flag_rx)));
endmodule

bind uart9_core uart9_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
  .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .tx_o(tx_o), .tx_busy(tx_busy), .flag_tx(flag_tx),
  .flag_rx(flag_rx), .cfg(cfg), .rx_b8_q(rx_b8_q), .irq_o(irq_o)
);

// File: tb/uart9_core_bench.sv
`timescale 1ns/1ps
module uart9_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_valid = 1'b0, reg_write = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_ready, tx_o, irq_o;
  logic [7:0] reg_rdata;
  logic       rx_line = 1'b1;
  int         n_tests = 0, n_fail = 0;
  logic [7:0] rd_v;
  logic [7:0] last_data = 8'h00;
  logic       last_b8 = 1'b0;

  always #5 clk = ~clk;

  uart9_core u_uart9_core (
    .clk(clk), .rst_n(rst_n), .baud_tick(1'b1), .reg_valid(reg_valid),
    .reg_ready(reg_ready), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_o(tx_o),
    .rx_i(rx_line), .irq_o(irq_o)
  );

  // {mode9, qual, ninth, stop, accepted, data}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h7E},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A},
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h11},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hF0}
  };

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic nine, input logic b8,
                         input logic stop);
    @(negedge clk); rx_line = 1'b0;
    repeat (16) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rx_line = d[k];
      repeat (16) @(negedge clk);
    end
    if (nine) begin
      rx_line = b8;
      repeat (16) @(negedge clk);
    end
    rx_line = stop;
    repeat (16) @(negedge clk);
    rx_line = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic tx_frame(input logic m, input logic b8, input logic [7:0] d);
    wr(1'b0, {4'b0000, b8, 2'b00, m});
    wr(1'b1, d);
    repeat (8) @(negedge clk);
    chk("R3 start bit", tx_o, 0);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 1'b1; reg_wdata = 8'hEE;
    #1 chk("R5 ready low while busy", reg_ready, 0);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    repeat (15) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      chk("R3 data bit", tx_o, d[k]);
      if (k == 7) chk("R4 flag low before stop", irq_o, 0);
      repeat (16) @(negedge clk);
    end
    if (m) begin
      chk("R3 ninth bit", tx_o, b8);
      chk("R4 flag low in ninth bit", irq_o, 0);
      repeat (16) @(negedge clk);
    end
    chk("R3 stop bit", tx_o, 1);
    chk("R4 R12 flag at stop start", irq_o, 1);
    repeat (16) @(negedge clk);
    chk("R11 tx flag held", irq_o, 1);
    chk("R5 ready when idle", reg_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1'b0, rd_v);
    chk("R1 ctrl reset", rd_v, 8'h40);
    chk("R1 tx idle", tx_o, 1);
    chk("R1 irq low", irq_o, 0);
    // R2 bit 6 and read-only bit 4, flags not settable
    wr(1'b0, 8'hFF);
    rd(1'b0, rd_v);
    chk("R2 R11 write all ones", rd_v, 8'h4F);
    wr(1'b0, 8'h00);
    rd(1'b0, rd_v);
    chk("R2 write zero", rd_v, 8'h40);

    // table of receive frames: R8 R9 R10
    for (int v = 0; v < 8; v++) begin
      logic [12:0] e;
      e = VEC[v];
      wr(1'b0, {5'b00000, e[11], 1'b1, e[12]});
      send_rx(e[7:0], e[12], e[10], e[9]);
      if (e[8]) begin
        last_data = e[7:0];
        last_b8   = e[12] ? e[10] : e[9];
      end
      rd(1'b0, rd_v);
      chk("R8 R9 receive flag", rd_v[7], e[8]);
      chk("R8 R9 R10 captured ninth", rd_v[4], last_b8);
      rd(1'b1, rd_v);
      chk("R10 data register", rd_v, last_data);
    end

    // R6 start glitch
    wr(1'b0, 8'h02);
    @(negedge clk); rx_line = 1'b0;
    repeat (4) @(negedge clk); rx_line = 1'b1;
    repeat (40) @(negedge clk);
    rd(1'b0, rd_v);
    chk("R6 glitch no flag", rd_v[7], 0);
    send_rx(8'h96, 1'b0, 1'b0, 1'b1);
    rd(1'b1, rd_v);
    chk("R6 frame after glitch", rd_v, 8'h96);

    // R7 receiver disabled
    wr(1'b0, 8'h00);
    send_rx(8'h99, 1'b0, 1'b0, 1'b1);
    rd(1'b0, rd_v);
    chk("R7 no flag when disabled", rd_v[7], 0);
    rd(1'b1, rd_v);
    chk("R7 data unchanged", rd_v, 8'h96);
    chk("R12 irq low no flags", irq_o, 0);

    // R11 set wins over same-cycle clear (stop sampled on 155th edge)
    wr(1'b0, 8'h02);
    fork
      send_rx(8'h6B, 1'b0, 1'b0, 1'b1);
      begin
        @(negedge clk);
        repeat (154) @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h02;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
      end
    join
    rd(1'b0, rd_v);
    chk("R11 set beats clear", rd_v[7], 1);
    rd(1'b1, rd_v);
    chk("R11 collision data", rd_v, 8'h6B);
    repeat (100) @(negedge clk);
    chk("R11 R12 flag held", irq_o, 1);
    wr(1'b0, 8'h02);
    chk("R11 cleared by write", irq_o, 0);

    // transmit frames R3 R4 R5
    tx_frame(1'b0, 1'b1, 8'hB4);
    tx_frame(1'b1, 1'b1, 8'h2D);
    tx_frame(1'b1, 1'b0, 8'h0F);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule